// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block sits on a host I/O request stream and turns indirect configuration accesses into requests for one downstream configuration target. Software first writes a 32-bit selector word into an address register at I/O `CFG_BASE` (0x0CF8 by default). It then reads or writes a four-byte data window at `CFG_BASE+4` to `CFG_BASE+7`. When the enable bit of the selector is set, each legal access to the window becomes one target request. That request carries the bus, device, function and dword register index from the selector, plus byte enables and lane-positioned write data.

Host traffic is valid/ready. `io_req_ready` is high only when nothing is in flight, so the host holds its request for as long as the block is busy. Every accepted access produces exactly one `io_rsp_valid` pulse, and the host must accept that pulse when it comes; the response path has no back-pressure. The target side is also valid/ready. A request's fields stay frozen until the target raises `tgt_ready`. A read then waits for a one-cycle `tgt_done` that carries `tgt_rdata`. Host data is right-justified: a byte sits in bits 7:0 and a word sits in bits 15:0. The block moves the data to the target's byte lanes and back.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the selector register is zero, `io_req_ready` is 1, `tgt_valid` is 0 and `io_rsp_valid` is 0.
- R2: A dword access (size code 2'b10 or 2'b11) at `CFG_BASE` loads the selector on a write, keeping bit 31 and bits 23:2 only. On a read it returns the stored value with bits 30:24 and 1:0 as zero. Writing 0x80000000 reads back as 0x80000000, and writing an old value back restores it.
- R3: An access at `CFG_BASE` to `CFG_BASE+3` that is not a dword at `CFG_BASE` leaves the selector unchanged. A read of that kind returns all ones across the access size: 0xFF for a byte (code 2'b00), 0xFFFF for a word (code 2'b01), 0xFFFFFFFF for a dword.
- R4: With selector bit 31 set, a fitting window access issues one target request. Its fields are bus = sel[23:16], device = sel[15:11], function = sel[10:8] and register index = sel[7:2].
- R5: For a forwarded access at window offset k (addr[1:0]) of n bytes, the byte enables are n consecutive ones starting at bit k. The target write data is the host data shifted left by 8*k.
- R6: A forwarded read returns `tgt_rdata` shifted right by 8*k, with bytes above n cleared.
- R7: With selector bit 31 clear, window reads return all ones across the access size, writes are dropped, and no target request is made.
- R8: A window access with k + n > 4 is handled as in R7 even when bit 31 is set.
- R9: Only one access is in flight. `io_req_ready` stays low from the acceptance of a forwarded access until its response. `tgt_valid` and every target field hold steady until `tgt_ready`.
- R10: A forwarded write responds in the cycle after the edge where `tgt_ready` is sampled high. A forwarded read responds in the cycle after the edge that samples `tgt_done`. Any other access responds in the cycle after acceptance. Write responses carry zero data.
- R11: An address outside `CFG_BASE` to `CFG_BASE+7` is not forwarded and does not touch the selector. A read of that kind returns all ones across the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req_valid | input | 1 | Host access present |
| io_req_ready | output | 1 | Block can accept an access |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | IO_AW | I/O byte address |
| io_req_size | input | 2 | 00 byte, 01 word, 1x dword |
| io_req_wdata | input | 32 | Right-justified write data |
| io_rsp_valid | output | 1 | One-cycle completion pulse |
| io_rsp_rdata | output | 32 | Right-justified read data, zero on writes |
| tgt_valid | output | 1 | Target request present |
| tgt_ready | input | 1 | Target takes the request |
| tgt_write | output | 1 | Target request is a write |
| tgt_bus | output | 8 | Bus number |
| tgt_dev | output | 5 | Device number |
| tgt_func | output | 3 | Function number |
| tgt_reg | output | 6 | Dword register index |
| tgt_be | output | 4 | Byte enables |
| tgt_wdata | output | 32 | Lane-positioned write data |
| tgt_done | input | 1 | Read data valid pulse |
| tgt_rdata | input | 32 | Lane-positioned read data |

## Verification
Two events can land in the same cycle: a read completing on `tgt_done` and the host's next access waiting on `io_req_valid`. The bench issues reads back to back without waiting for responses, so the next request is already being held when the target's done pulse arrives. Ready and done latencies are varied between runs. The scoreboard requires the completed read to return its own steered data, and the waiting access to be taken only afterwards, with its own result and its own target fields.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {
    ACT_REG  = 2'd0,
    ACT_FILL = 2'd1,
    ACT_FWD  = 2'd2
  } act_e;

  typedef struct packed {
    logic        write;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  func;
    logic [5:0]  reg_idx;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_req_t;

  localparam logic [31:0] SEL_KEEP = 32'h80FF_FFFC;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_ones(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgw_sel_reg.sv
module cfgw_sel_reg
  import cfgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_data,
  output logic [31:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (ld) sel_q <= ld_data & SEL_KEEP;
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(sel_q));

  // R2
  sel_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (sel_q[30:24] == 7'd0) && (sel_q[1:0] == 2'd0));

endmodule

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter int unsigned         IO_AW    = 16,
  parameter logic [IO_AW-1:0]    CFG_BASE = 16'h0CF8
) (
  input  logic [IO_AW-1:0] addr,
  input  logic [1:0]       size,
  input  logic             write,
  input  logic [31:0]      wdata,
  input  logic [31:0]      sel_q,
  output act_e             action,
  output cfg_req_t         req,
  output logic [31:0]      local_rdata
);

  localparam logic [IO_AW-1:0] BLK_MASK = ~IO_AW'(7);

  logic       hit;
  logic [1:0] off;
  logic [2:0] nbytes;
  logic [3:0] span;
  logic       fits;
  logic [4:0] run;
  logic [7:0] lanes;

  always_comb begin
    hit    = (addr & BLK_MASK) == CFG_BASE;
    off    = addr[1:0];
    nbytes = size_bytes(size);
    span   = {2'b00, off} + {1'b0, nbytes};
    fits   = span <= 4'd4;
    run    = (5'd1 << nbytes) - 5'd1;
    lanes  = {3'b000, run} << off;

    if (hit && !addr[2] && off == 2'd0 && size[1]) begin
      action      = ACT_REG;
      local_rdata = write ? 32'd0 : sel_q;
    end else if (hit && addr[2] && sel_q[31] && fits) begin
      action      = ACT_FWD;
      local_rdata = 32'd0;
    end else begin
      action      = ACT_FILL;
      local_rdata = write ? 32'd0 : size_ones(size);
    end

    req.write   = write;
    req.bus     = sel_q[23:16];
    req.dev     = sel_q[15:11];
    req.func    = sel_q[10:8];
    req.reg_idx = sel_q[7:2];
    req.be      = lanes[3:0];
    req.wdata   = wdata << {off, 3'b000};
  end

  // R5
  be_width_chk: assert final ((action != ACT_FWD) ||
    ($countones(req.be) == int'(nbytes)));

endmodule

// File: rtl/cfgw_ctrl.sv
module cfgw_ctrl
  import cfgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req_valid,
  input  act_e        action,
  input  cfg_req_t    req,
  input  logic [31:0] local_rdata,
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  output logic        io_req_ready,
  output logic        accept,
  output logic        io_rsp_valid,
  output logic [31:0] io_rsp_rdata,
  output logic        tgt_valid,
  output cfg_req_t    tgt_req,
  input  logic        tgt_ready,
  input  logic        tgt_done,
  input  logic [31:0] tgt_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e        st;
  logic [1:0] off_q;
  logic [1:0] size_q;

  assign io_req_ready = (st == ST_IDLE);
  assign accept       = io_req_valid && io_req_ready;
  assign tgt_valid    = (st == ST_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      off_q        <= '0;
      size_q       <= '0;
      tgt_req      <= '0;
      io_rsp_valid <= 1'b0;
      io_rsp_rdata <= '0;
    end else begin
      io_rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (action == ACT_FWD) begin
            tgt_req <= req;
            off_q   <= off;
            size_q  <= size;
            st      <= ST_ISSUE;
          end else begin
            io_rsp_valid <= 1'b1;
            io_rsp_rdata <= local_rdata;
          end
        end
        ST_ISSUE: if (tgt_ready) begin
          if (tgt_req.write) begin
            io_rsp_valid <= 1'b1;
            io_rsp_rdata <= 32'd0;
            st           <= ST_IDLE;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: if (tgt_done) begin
          io_rsp_valid <= 1'b1;
          io_rsp_rdata <= (tgt_rdata >> {off_q, 3'b000}) & size_ones(size_q);
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_req));

  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !io_req_ready);

  // R9
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_valid) |-> $past(io_req_valid));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> ($countones(tgt_req.be) == 1 || $countones(tgt_req.be) == 2 ||
                   tgt_req.be == 4'hF));

  // R10
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && tgt_ready && tgt_req.write |=> io_rsp_valid && io_rsp_rdata == 32'd0);

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgw_pkg::*;
#(
  parameter int unsigned      IO_AW    = 16,
  parameter logic [IO_AW-1:0] CFG_BASE = 16'h0CF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req_valid,
  output logic             io_req_ready,
  input  logic             io_req_write,
  input  logic [IO_AW-1:0] io_req_addr,
  input  logic [1:0]       io_req_size,
  input  logic [31:0]      io_req_wdata,
  output logic             io_rsp_valid,
  output logic [31:0]      io_rsp_rdata,
  output logic             tgt_valid,
  input  logic             tgt_ready,
  output logic             tgt_write,
  output logic [7:0]       tgt_bus,
  output logic [4:0]       tgt_dev,
  output logic [2:0]       tgt_func,
  output logic [5:0]       tgt_reg,
  output logic [3:0]       tgt_be,
  output logic [31:0]      tgt_wdata,
  input  logic             tgt_done,
  input  logic [31:0]      tgt_rdata
);

  logic [31:0] sel_q;
  act_e        action;
  cfg_req_t    dec_req;
  cfg_req_t    tgt_req;
  logic [31:0] local_rdata;
  logic        accept;
  logic        sel_ld;

  assign sel_ld = accept && (action == ACT_REG) && io_req_write;

  cfgw_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (sel_ld),
    .ld_data (io_req_wdata),
    .sel_q   (sel_q)
  );

  cfgw_decode #(.IO_AW(IO_AW), .CFG_BASE(CFG_BASE)) u_dec (
    .addr        (io_req_addr),
    .size        (io_req_size),
    .write       (io_req_write),
    .wdata       (io_req_wdata),
    .sel_q       (sel_q),
    .action      (action),
    .req         (dec_req),
    .local_rdata (local_rdata)
  );

  cfgw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_req_valid (io_req_valid),
    .action       (action),
    .req          (dec_req),
    .local_rdata  (local_rdata),
    .off          (io_req_addr[1:0]),
    .size         (io_req_size),
    .io_req_ready (io_req_ready),
    .accept       (accept),
    .io_rsp_valid (io_rsp_valid),
    .io_rsp_rdata (io_rsp_rdata),
    .tgt_valid    (tgt_valid),
    .tgt_req      (tgt_req),
    .tgt_ready    (tgt_ready),
    .tgt_done     (tgt_done),
    .tgt_rdata    (tgt_rdata)
  );

  assign tgt_write = tgt_req.write;
  assign tgt_bus   = tgt_req.bus;
  assign tgt_dev   = tgt_req.dev;
  assign tgt_func  = tgt_req.func;
  assign tgt_reg   = tgt_req.reg_idx;
  assign tgt_be    = tgt_req.be;
  assign tgt_wdata = tgt_req.wdata;

  // R7
  fwd_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_valid) |-> sel_q[31]);

  // R2
  sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |=> $stable(sel_q));

endmodule

// File: tb/cfg_window_bridge_tb.sv
module cfg_window_bridge_tb;
  import cfgw_pkg::*;

  localparam logic [15:0] BASE = 16'h0CF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req_valid = 1'b0;
  logic        io_req_ready;
  logic        io_req_write = 1'b0;
  logic [15:0] io_req_addr = '0;
  logic [1:0]  io_req_size = '0;
  logic [31:0] io_req_wdata = '0;
  logic        io_rsp_valid;
  logic [31:0] io_rsp_rdata;
  logic        tgt_valid;
  logic        tgt_ready = 1'b0;
  logic        tgt_write;
  logic [7:0]  tgt_bus;
  logic [4:0]  tgt_dev;
  logic [2:0]  tgt_func;
  logic [5:0]  tgt_reg;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic        tgt_done = 1'b0;
  logic [31:0] tgt_rdata = '0;

  always #10 clk = ~clk;

  cfg_window_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_addr(io_req_addr),
    .io_req_size(io_req_size), .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_rdata(io_rsp_rdata),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_write(tgt_write),
    .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_func(tgt_func),
    .tgt_reg(tgt_reg), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
    .tgt_done(tgt_done), .tgt_rdata(tgt_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int rdy_lat = 0;
  int rd_lat = 0;

  logic [31:0] exp_q[$];
  int          tag_q[$];
  cfg_req_t    tgt_q[$];
  logic [31:0] sel_model = '0;

  function automatic logic [31:0] tgt_pattern(input cfg_req_t r);
    return {2'b10, r.reg_idx, r.func, r.dev, r.bus, 8'h5A};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Scoreboard driver: computes expected result, pushes it, presents request.
  task automatic io_acc(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int tag);
    int          nb;
    int          k;
    logic [31:0] ones;
    logic [31:0] exp;
    cfg_req_t    r;
    nb   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    ones = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    k    = int'(a[1:0]);
    exp  = wr ? 32'd0 : ones;
    if (a == BASE && sz[1]) begin
      if (wr) sel_model = wd & 32'h80FF_FFFC;      // R2
      else exp = sel_model;
    end else if ((a & 16'hFFF8) == BASE && a[2] && sel_model[31] && (k + nb <= 4)) begin
      r.write   = wr;                               // R4 fields
      r.bus     = sel_model[23:16];
      r.dev     = sel_model[15:11];
      r.func    = sel_model[10:8];
      r.reg_idx = sel_model[7:2];
      r.be      = 4'(((1 << nb) - 1) << k);         // R5
      r.wdata   = wd << (8 * k);
      tgt_q.push_back(r);
      if (!wr) exp = (tgt_pattern(r) >> (8 * k)) & ones;  // R6
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    io_req_write = wr;
    io_req_addr  = a;
    io_req_size  = sz;
    io_req_wdata = wd;
    io_req_valid = 1'b1;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic io_idle();
    io_req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected responses
  initial begin
    forever begin
      @(negedge clk);
      if (io_rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", io_rsp_rdata, 32'hx);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic int t = tag_q.pop_front();
          check(io_rsp_rdata === e, $sformatf("R%0d response data", t), io_rsp_rdata, e);
        end
      end
    end
  end

  // Target model
  initial begin
    automatic bit       acc_now = 1'b0;
    automatic bit       pend = 1'b0;
    automatic int       wcnt = 0;
    automatic int       rcnt = 0;
    automatic cfg_req_t cur = '0;
    forever begin
      @(negedge clk);
      tgt_done = 1'b0;
      if (acc_now) begin
        acc_now   = 1'b0;
        tgt_ready = 1'b0;
        if (!cur.write) begin
          pend = 1'b1;
          wcnt = rd_lat;
        end
      end else if (pend) begin
        if (wcnt == 0) begin
          tgt_done  = 1'b1;
          tgt_rdata = tgt_pattern(cur);
          pend      = 1'b0;
        end else wcnt--;
      end else if (tgt_valid) begin
        if (rcnt >= rdy_lat) begin
          rcnt = 0;
          cur  = {tgt_write, tgt_bus, tgt_dev, tgt_func, tgt_reg, tgt_be, tgt_wdata};
          if (tgt_q.size() == 0) begin
            check(1'b0, "R7 request not expected", {31'd0, tgt_valid}, 32'd0);
          end else begin
            automatic cfg_req_t e = tgt_q.pop_front();
            check(cur[63:32] === e[63:32], "R4 target fields", cur[63:32], e[63:32]);
            check(cur.wdata === e.wdata, "R5 target lanes", cur.wdata, e.wdata);
          end
          tgt_ready = 1'b1;
          acc_now   = 1'b1;
        end else rcnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(io_req_ready === 1'b1, "R1 ready after reset", {31'd0, io_req_ready}, 32'd1);
    check(tgt_valid === 1'b0, "R1 tgt_valid after reset", {31'd0, tgt_valid}, 32'd0);
    check(io_rsp_valid === 1'b0, "R1 rsp_valid after reset", {31'd0, io_rsp_valid}, 32'd0);
    io_acc(1'b0, BASE, 2'b10, 0, 1);                 // R1 selector reads zero

    // R7 enable clear
    io_acc(1'b0, BASE + 5, 2'b00, 0, 7);
    io_acc(1'b0, BASE + 4, 2'b10, 0, 7);
    io_acc(1'b1, BASE + 4, 2'b10, 32'h1234_5678, 7);

    // R2 round trip and restore
    io_acc(1'b1, BASE, 2'b10, 32'h8000_0000, 2);
    io_acc(1'b0, BASE, 2'b10, 0, 2);
    io_acc(1'b1, BASE, 2'b10, 32'h0000_0000, 2);
    io_acc(1'b0, BASE, 2'b10, 0, 2);
    io_acc(1'b1, BASE, 2'b11, 32'hFFFF_FFFF, 2);
    io_acc(1'b0, BASE, 2'b10, 0, 2);

    // R3 narrow or misaligned selector accesses
    io_acc(1'b1, BASE + 3, 2'b00, 32'h01, 3);
    io_acc(1'b1, BASE + 2, 2'b01, 32'h0000, 3);
    io_acc(1'b0, BASE, 2'b10, 0, 3);
    io_acc(1'b0, BASE + 2, 2'b01, 0, 3);
    io_acc(1'b0, BASE + 1, 2'b10, 0, 3);
    io_acc(1'b0, BASE, 2'b00, 0, 3);

    // R4 R6 forwarded reads, all offsets and sizes
    io_acc(1'b1, BASE, 2'b10, 32'h8012_AB3F, 4);
    io_acc(1'b0, BASE + 4, 2'b10, 0, 4);
    for (int i = 0; i < 4; i++) io_acc(1'b0, BASE + 4 + 16'(i), 2'b00, 0, 6);
    io_acc(1'b0, BASE + 4, 2'b01, 0, 6);
    io_acc(1'b0, BASE + 5, 2'b01, 0, 6);
    io_acc(1'b0, BASE + 6, 2'b01, 0, 6);

    // R8 accesses crossing the window end
    io_acc(1'b0, BASE + 7, 2'b01, 0, 8);
    io_acc(1'b0, BASE + 5, 2'b10, 0, 8);
    io_acc(1'b1, BASE + 6, 2'b10, 32'hDEAD_BEEF, 8);

    // R5 R10 forwarded writes with slow target
    rdy_lat = 2;
    io_acc(1'b1, BASE + 6, 2'b00, 32'h77, 5);
    io_acc(1'b1, BASE + 5, 2'b01, 32'hBEEF, 5);
    io_acc(1'b1, BASE + 4, 2'b10, 32'hCAFE_F00D, 10);

    // R9 R10 back-to-back reads: done coincides with a held request
    rd_lat = 3;
    io_acc(1'b1, BASE, 2'b10, 32'h80FF_F8FC, 9);
    io_acc(1'b0, BASE + 4, 2'b10, 0, 9);
    io_acc(1'b0, BASE + 7, 2'b00, 0, 9);
    rdy_lat = 0;
    rd_lat  = 0;
    io_acc(1'b0, BASE + 6, 2'b01, 0, 9);
    io_acc(1'b0, BASE, 2'b10, 0, 9);

    // R11 outside the decoded range
    io_acc(1'b0, 16'h0080, 2'b10, 0, 11);
    io_acc(1'b1, 16'h0CF0, 2'b10, 32'h0, 11);
    io_acc(1'b0, 16'h0D00, 2'b00, 0, 11);
    io_acc(1'b0, BASE, 2'b10, 0, 11);
    io_idle();

    drain();
    repeat (5) @(negedge clk);
    check(tgt_q.size() == 0, "R4 all expected target requests seen",
          32'(tgt_q.size()), 32'd0);
    check(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule